// File: doc/BRIEF.md
# Queue Barrier Blocking Controller

This controller sits beside one command queue and decides, cycle by cycle, whether the queue may hand a new packet onward. It tracks three externally visible conditions: open, held by a packet whose barrier bit is set, and held by a barrier packet. A packet with its barrier bit set holds the queue until every packet accepted so far, itself included, has reported completion. A barrier packet holds the queue until all of its dependency signals read back as satisfied.

For a barrier packet the controller latches up to five signal handles, marks every non-null slot unsatisfied, and issues one read per non-null handle over a tagged request/response port. It counts outstanding reads, stores each returned value in the slot named by the response tag, and raises an internal all-returned flag when the round is over. If any value is non-zero it waits a programmable number of cycles and reads the whole set again. When the queue is unmapped while reads are still in flight, the controller enters a discard mode: returning values are dropped, and the queue reopens only after the last outstanding read has come back.

Top module: `qbb_ctrl`

## Requirements
- R1: `q_state` reads 0 when open, 1 when held by a barrier bit, 2 when held by a barrier packet; it never reads 3, it is 0 after reset, and `accept_ok` is high only while `q_state` is 0. A packet is taken when `pkt_valid` is high in a cycle where `accept_ok` is high.
- R2: A taken packet that is neither a barrier packet nor carries the barrier bit leaves `q_state` at 0.
- R3: A taken non-barrier packet with `pkt_bbit` set moves `q_state` to 1; it returns to 0 one cycle after the count of taken-but-not-completed non-barrier packets (one `cmp_valid` pulse each) reaches zero.
- R4: A taken barrier packet (`pkt_is_barrier` high) moves `q_state` to 2 and it stays 2 until a read round returns zero for every non-null handle; no signal read is requested while `q_state` is not 2.
- R5: Handle slot i sits at `pkt_handles[i*HANDLE_W +: HANDLE_W]`, i = 0..4. Each round issues exactly one request per non-zero handle, in slot order, with `sig_req_tag` equal to the slot index; a zero handle is never requested and counts as satisfied, so a barrier with only zero handles releases without any request. A request fires when `sig_req_valid` and `sig_req_ready` are both high.
- R6: Before every round all non-null slots are reset to unsatisfied; if any non-null value read back is non-zero, the next round starts no earlier than `retry_dly`+1 cycles after the last response of the previous round.
- R7: At most five reads are outstanding; a response arriving with no read outstanding is ignored.
- R8: An `unmap` pulse while reads are outstanding raises `discard_busy`, keeps `q_state` at 2 and `accept_ok` low, issues no further request, drops returning values, lowers `discard_busy` at the edge on which the last outstanding response is taken, and shows `q_state` 0 one cycle later.
- R9: An `unmap` pulse with no read outstanding returns `q_state` to 0 on the next cycle and clears the count of uncompleted packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | A packet is offered |
| pkt_is_barrier | input | 1 | Offered packet is a barrier packet |
| pkt_bbit | input | 1 | Barrier bit of the offered packet |
| pkt_handles | input | N_DEP*HANDLE_W | Dependency signal handles, slot i in bits i*HANDLE_W upward |
| accept_ok | output | 1 | Queue may take a packet this cycle |
| cmp_valid | input | 1 | One earlier non-barrier packet completed |
| sig_req_valid | output | 1 | Signal read request |
| sig_req_ready | input | 1 | Request accepted |
| sig_req_handle | output | HANDLE_W | Handle to read |
| sig_req_tag | output | TAG_W | Slot index of the request |
| sig_rsp_valid | input | 1 | Signal value returned |
| sig_rsp_tag | input | TAG_W | Slot index of the response |
| sig_rsp_value | input | VALUE_W | Returned signal value, zero means satisfied |
| unmap | input | 1 | Queue unmapped |
| retry_dly | input | DLY_W | Idle cycles before a repeated read round |
| q_state | output | 2 | 0 open, 1 barrier-bit hold, 2 barrier-packet hold |
| discard_busy | output | 1 | In-flight responses are being discarded |

## Verification
The bench sweeps all 32 null/non-null handle patterns, once with a ready that is always high and once with a ready that toggles, and counts requests per barrier; a controller that requested null handles, skipped a live slot or mis-tagged one would show a wrong count or tag. Release timing of the barrier-bit hold is checked to the cycle, catching an off-by-one in the uncompleted-packet count. An unsatisfied signal forces repeated rounds, where the bench measures the idle gap so a missing back-off would show up as rounds packed too close. Unmap is exercised with all five reads held in flight, where early clearing of the discard flag or a fresh request during the drain is reported, and again with no reads outstanding, where a count left uncleared would keep a later barrier-bit hold stuck.

// File: rtl/qbb_pkg.sv
package qbb_pkg;

    // Externally visible queue condition; encoding is part of the interface.
    typedef enum logic [1:0] {
        QS_OPEN = 2'd0,
        QS_BBIT = 2'd1,
        QS_BPKT = 2'd2
    } qstate_e;

    // Internal sequencing states of the controller.
    typedef enum logic [2:0] {
        ST_OPEN,
        ST_BIT_WAIT,
        ST_PREP,
        ST_ISSUE,
        ST_COLLECT,
        ST_EVAL,
        ST_BACKOFF,
        ST_DRAIN
    } fsm_e;

endpackage

// File: rtl/qbb_inflight.sv
module qbb_inflight #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    input  logic dec_i,
    input  logic clr_i,
    output logic zero_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             dec_ok;
    logic             inc_ok;

    assign dec_ok = dec_i && (cnt_q != '0);
    assign inc_ok = inc_i && (cnt_q != CNT_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (inc_ok && !dec_ok) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec_ok && !inc_ok) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/qbb_backoff.sv
module qbb_backoff #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             expired_o
);
    logic [DLY_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load_i) begin
            left_q <= dly_i;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign expired_o = (left_q == '0);

endmodule

// File: rtl/qbb_sig_tracker.sv
module qbb_sig_tracker #(
    parameter int N_DEP    = 5,
    parameter int HANDLE_W = 16,
    parameter int VALUE_W  = 16,
    parameter int TAG_W    = 3,
    parameter int PEND_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic [N_DEP*HANDLE_W-1:0] handles_i,
    input  logic                      prep_i,
    input  logic [TAG_W-1:0]          sel_i,
    input  logic                      fire_i,
    input  logic                      issue_done_i,
    input  logic                      unmap_i,
    input  logic                      rsp_valid_i,
    input  logic [TAG_W-1:0]          rsp_tag_i,
    input  logic [VALUE_W-1:0]        rsp_value_i,
    output logic [HANDLE_W-1:0]       sel_handle_o,
    output logic [PEND_W-1:0]         pending_o,
    output logic                      drain_need_o,
    output logic                      discard_o,
    output logic                      all_read_o,
    output logic                      all_zero_o
);
    logic [HANDLE_W-1:0] hnd_q [N_DEP];
    logic [VALUE_W-1:0]  val_q [N_DEP];
    logic [N_DEP-1:0]    zero_vec;
    logic [PEND_W-1:0]   pend_q;
    logic [PEND_W-1:0]   pend_nx;
    logic                discard_q;
    logic                issued_q;
    logic                all_read_q;
    logic                rsp_take;
    logic                rsp_keep;

    assign rsp_take = rsp_valid_i && (pend_q != '0);
    assign rsp_keep = rsp_take && !discard_q;
    assign pend_nx  = pend_q + PEND_W'(fire_i) - PEND_W'(rsp_take);

    // One storage slot per dependency signal.
    for (genvar g = 0; g < N_DEP; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hnd_q[g] <= '0;
                val_q[g] <= VALUE_W'(1);
            end else begin
                if (load_i) begin
                    hnd_q[g] <= handles_i[g*HANDLE_W +: HANDLE_W];
                end
                if (prep_i) begin
                    val_q[g] <= (hnd_q[g] == '0) ? '0 : VALUE_W'(1);
                end else if (rsp_keep && (rsp_tag_i == TAG_W'(g))) begin
                    val_q[g] <= rsp_value_i;
                end
            end
        end
        assign zero_vec[g] = (val_q[g] == '0);
    end

    always_comb begin
        sel_handle_o = '0;
        for (int i = 0; i < N_DEP; i++) begin
            if (sel_i == TAG_W'(i)) begin
                sel_handle_o = hnd_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= '0;
            discard_q  <= 1'b0;
            issued_q   <= 1'b0;
            all_read_q <= 1'b0;
        end else begin
            pend_q    <= pend_nx;
            discard_q <= unmap_i ? (pend_nx != '0) : (discard_q && (pend_nx != '0));
            if (prep_i || unmap_i) begin
                issued_q   <= 1'b0;
                all_read_q <= 1'b0;
            end else begin
                if (issue_done_i) begin
                    issued_q <= 1'b1;
                end
                if ((issued_q || issue_done_i) && (pend_nx == '0)) begin
                    all_read_q <= 1'b1;
                end
            end
        end
    end

    assign pending_o    = pend_q;
    assign drain_need_o = (pend_nx != '0);
    assign discard_o    = discard_q;
    assign all_read_o   = all_read_q;
    assign all_zero_o   = &zero_vec;

endmodule

// File: rtl/qbb_ctrl.sv
module qbb_ctrl
    import qbb_pkg::*;
#(
    parameter int N_DEP    = 5,
    parameter int HANDLE_W = 16,
    parameter int VALUE_W  = 16,
    parameter int CNT_W    = 8,
    parameter int DLY_W    = 8,
    localparam int TAG_W   = (N_DEP > 1) ? $clog2(N_DEP) : 1,
    localparam int PEND_W  = $clog2(N_DEP + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pkt_valid,
    input  logic                      pkt_is_barrier,
    input  logic                      pkt_bbit,
    input  logic [N_DEP*HANDLE_W-1:0] pkt_handles,
    output logic                      accept_ok,
    input  logic                      cmp_valid,
    output logic                      sig_req_valid,
    input  logic                      sig_req_ready,
    output logic [HANDLE_W-1:0]       sig_req_handle,
    output logic [TAG_W-1:0]          sig_req_tag,
    input  logic                      sig_rsp_valid,
    input  logic [TAG_W-1:0]          sig_rsp_tag,
    input  logic [VALUE_W-1:0]        sig_rsp_value,
    input  logic                      unmap,
    input  logic [DLY_W-1:0]          retry_dly,
    output logic [1:0]                q_state,
    output logic                      discard_busy
);
    localparam logic [TAG_W-1:0] LAST_SLOT = TAG_W'(N_DEP - 1);

    fsm_e              st_q, st_nx;
    logic [TAG_W-1:0]  slot_q;
    logic              take_pkt;
    logic              take_barrier;
    logic              take_plain;
    logic              out_zero;
    logic              bo_expired;
    logic [HANDLE_W-1:0] cur_handle;
    logic              cur_null;
    logic              step;
    logic              fire;
    logic              issue_done;
    logic [PEND_W-1:0] pend_cnt;
    logic              drain_need;
    logic              discard;
    logic              all_read;
    logic              all_zero;

    assign take_pkt     = pkt_valid && (st_q == ST_OPEN) && !unmap;
    assign take_barrier = take_pkt && pkt_is_barrier;
    assign take_plain   = take_pkt && !pkt_is_barrier;
    assign cur_null     = (cur_handle == '0);
    assign fire         = (st_q == ST_ISSUE) && !cur_null && sig_req_ready;
    assign step         = (st_q == ST_ISSUE) && (cur_null || sig_req_ready);
    assign issue_done   = step && (slot_q == LAST_SLOT);

    qbb_inflight #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (take_plain),
        .dec_i  (cmp_valid),
        .clr_i  (unmap),
        .zero_o (out_zero)
    );

    qbb_backoff #(.DLY_W(DLY_W)) u_bo (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (st_q == ST_EVAL),
        .dly_i     (retry_dly),
        .expired_o (bo_expired)
    );

    qbb_sig_tracker #(
        .N_DEP    (N_DEP),
        .HANDLE_W (HANDLE_W),
        .VALUE_W  (VALUE_W),
        .TAG_W    (TAG_W),
        .PEND_W   (PEND_W)
    ) u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (take_barrier),
        .handles_i    (pkt_handles),
        .prep_i       (st_q == ST_PREP),
        .sel_i        (slot_q),
        .fire_i       (fire),
        .issue_done_i (issue_done),
        .unmap_i      (unmap),
        .rsp_valid_i  (sig_rsp_valid),
        .rsp_tag_i    (sig_rsp_tag),
        .rsp_value_i  (sig_rsp_value),
        .sel_handle_o (cur_handle),
        .pending_o    (pend_cnt),
        .drain_need_o (drain_need),
        .discard_o    (discard),
        .all_read_o   (all_read),
        .all_zero_o   (all_zero)
    );

    // Next-state selection.
    always_comb begin
        st_nx = st_q;
        if (unmap) begin
            st_nx = drain_need ? ST_DRAIN : ST_OPEN;
        end else begin
            unique case (st_q)
                ST_OPEN: begin
                    if (take_barrier) begin
                        st_nx = ST_PREP;
                    end else if (take_plain && pkt_bbit) begin
                        st_nx = ST_BIT_WAIT;
                    end
                end
                ST_BIT_WAIT: if (out_zero)   st_nx = ST_OPEN;
                ST_PREP:                     st_nx = ST_ISSUE;
                ST_ISSUE:    if (issue_done) st_nx = ST_COLLECT;
                ST_COLLECT:  if (all_read)   st_nx = ST_EVAL;
                ST_EVAL:     st_nx = all_zero ? ST_OPEN : ST_BACKOFF;
                ST_BACKOFF:  if (bo_expired) st_nx = ST_PREP;
                ST_DRAIN: begin
                    if (pend_cnt == '0) begin
                        st_nx = ST_OPEN;
                    end
                end
                default:                     st_nx = ST_OPEN;
            endcase
        end
    end

    // State and slot pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_OPEN;
            slot_q <= '0;
        end else begin
            st_q <= st_nx;
            if (st_q == ST_PREP) begin
                slot_q <= '0;
            end else if (step && !issue_done) begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        accept_ok      = 1'b0;
        sig_req_valid  = 1'b0;
        sig_req_handle = cur_handle;
        sig_req_tag    = slot_q;
        discard_busy   = discard;
        q_state        = QS_BPKT;
        unique case (st_q)
            ST_OPEN: begin
                q_state   = QS_OPEN;
                accept_ok = 1'b1;
            end
            ST_BIT_WAIT: q_state = QS_BBIT;
            ST_ISSUE:    sig_req_valid = !cur_null;
            default:     q_state = QS_BPKT;
        endcase
    end

endmodule

// File: rtl/qbb_ctrl_chk.sv
module qbb_ctrl_chk #(
    parameter int N_DEP    = 5,
    parameter int HANDLE_W = 16,
    parameter int PEND_W   = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                accept_ok,
    input logic [1:0]          q_state,
    input logic                sig_req_valid,
    input logic [HANDLE_W-1:0] sig_req_handle,
    input logic                discard_busy,
    input logic [PEND_W-1:0]   pending
);
    a_r1_accept_only_open: assert property (@(posedge clk) disable iff (!rst_n)
        accept_ok |-> (q_state == 2'd0));

    a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        q_state != 2'd3);

    a_r4_req_only_in_bpkt: assert property (@(posedge clk) disable iff (!rst_n)
        (q_state != 2'd2) |-> !sig_req_valid);

    a_r5_no_null_request: assert property (@(posedge clk) disable iff (!rst_n)
        sig_req_valid |-> (sig_req_handle != '0));

    a_r7_pending_cap: assert property (@(posedge clk) disable iff (!rst_n)
        pending <= PEND_W'(N_DEP));

    a_r8_discard_holds: assert property (@(posedge clk) disable iff (!rst_n)
        discard_busy |-> ((q_state == 2'd2) && !accept_ok && !sig_req_valid));

    a_r8_discard_ends_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(discard_busy) |-> (pending == '0));

    a_r8_discard_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        discard_busy |-> (pending != '0));

endmodule

bind qbb_ctrl qbb_ctrl_chk #(
    .N_DEP    (N_DEP),
    .HANDLE_W (HANDLE_W),
    .PEND_W   (PEND_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .accept_ok      (accept_ok),
    .q_state        (q_state),
    .sig_req_valid  (sig_req_valid),
    .sig_req_handle (sig_req_handle),
    .discard_busy   (discard_busy),
    .pending        (pend_cnt)
);

// File: tb/sim_qbb_ctrl.sv
`timescale 1ns/1ps
module sim_qbb_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N_DEP = 5;
    localparam int HW    = 8;
    localparam int VW    = 8;
    localparam int DW    = 4;
    localparam int TW    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pkt_valid = 1'b0, pkt_is_barrier = 1'b0, pkt_bbit = 1'b0;
    logic [N_DEP*HW-1:0] pkt_handles = '0;
    logic accept_ok;
    logic cmp_valid = 1'b0;
    logic sig_req_valid;
    logic sig_req_ready = 1'b1;
    logic [HW-1:0] sig_req_handle;
    logic [TW-1:0] sig_req_tag;
    logic sig_rsp_valid = 1'b0;
    logic [TW-1:0] sig_rsp_tag = '0;
    logic [VW-1:0] sig_rsp_value = '0;
    logic unmap = 1'b0;
    logic [DW-1:0] retry_dly = 4'd4;
    logic [1:0] q_state;
    logic discard_busy;

    int checks = 0, fails = 0;
    int nreq = 0, cyc = 0, last_rsp_cyc = 0, min_gap = 1000, tag0_fires = 0;
    logic [VW-1:0] sigmem [256];
    logic [TW-1:0] q_tag [16];
    logic [HW-1:0] q_hnd [16];
    int q_cnt = 0;
    bit hold = 1'b0, rdy_toggle = 1'b0, sweep_mode = 1'b0;
    int rel_cnt = 0;

    qbb_ctrl #(.N_DEP(N_DEP), .HANDLE_W(HW), .VALUE_W(VW), .CNT_W(6), .DLY_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_is_barrier(pkt_is_barrier),
        .pkt_bbit(pkt_bbit), .pkt_handles(pkt_handles), .accept_ok(accept_ok),
        .cmp_valid(cmp_valid), .sig_req_valid(sig_req_valid), .sig_req_ready(sig_req_ready),
        .sig_req_handle(sig_req_handle), .sig_req_tag(sig_req_tag),
        .sig_rsp_valid(sig_rsp_valid), .sig_rsp_tag(sig_rsp_tag), .sig_rsp_value(sig_rsp_value),
        .unmap(unmap), .retry_dly(retry_dly), .q_state(q_state), .discard_busy(discard_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Signal memory responder: answers requests in issue order.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (rdy_toggle) sig_req_ready = ~sig_req_ready;
            else            sig_req_ready = 1'b1;
            if (q_cnt > 0 && (!hold || rel_cnt > 0)) begin
                sig_rsp_valid = 1'b1;
                sig_rsp_tag   = q_tag[0];
                sig_rsp_value = sigmem[q_hnd[0]];
                for (int i = 0; i < 15; i++) begin
                    q_tag[i] = q_tag[i+1];
                    q_hnd[i] = q_hnd[i+1];
                end
                q_cnt--;
                if (rel_cnt > 0) rel_cnt--;
                last_rsp_cyc = cyc;
            end else begin
                sig_rsp_valid = 1'b0;
            end
            if (sig_req_valid && sig_req_ready) begin
                q_tag[q_cnt] = sig_req_tag;
                q_hnd[q_cnt] = sig_req_handle;
                q_cnt++;
                nreq++;
                if (sweep_mode) // R5: slot i carries handle (i+1)*10
                    chk(int'(sig_req_handle) == (int'(sig_req_tag) + 1) * 10, "R5 tag/handle",
                        int'(sig_req_handle), (int'(sig_req_tag) + 1) * 10);
                if (sig_req_tag == '0) begin
                    if (tag0_fires > 0 && (cyc - last_rsp_cyc) < min_gap)
                        min_gap = cyc - last_rsp_cyc;
                    tag0_fires++;
                end
            end
        end
    end

    task automatic send_pkt(input bit barrier, input bit bbit, input logic [N_DEP*HW-1:0] h);
        @(negedge clk);
        pkt_valid = 1'b1; pkt_is_barrier = barrier; pkt_bbit = bbit; pkt_handles = h;
        @(posedge clk);
        #1;
        pkt_valid = 1'b0; pkt_is_barrier = 1'b0; pkt_bbit = 1'b0;
    endtask

    task automatic complete_one();
        @(negedge clk);
        cmp_valid = 1'b1;
        @(posedge clk);
        #1;
        cmp_valid = 1'b0;
    endtask

    task automatic pulse_unmap();
        @(negedge clk);
        unmap = 1'b1;
        @(posedge clk);
        #1;
        unmap = 1'b0;
    endtask

    task automatic wait_open(input int maxc, output int used);
        used = 0;
        while (q_state != 2'd0 && used < maxc) begin
            tick();
            used++;
        end
    endtask

    task automatic release_one();
        rel_cnt = 1;
        @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    initial begin
        int used;
        logic [N_DEP*HW-1:0] h;
        for (int i = 0; i < 256; i++) sigmem[i] = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk(q_state == 2'd0, "R1 reset q_state", q_state, 0);
        chk(accept_ok == 1'b1, "R1 reset accept_ok", accept_ok, 1);
        chk(discard_busy == 1'b0, "R8 reset discard", discard_busy, 0);

        // R2: plain packets keep the queue open
        send_pkt(0, 0, '0);
        chk(q_state == 2'd0, "R2 plain pkt", q_state, 0);
        send_pkt(0, 0, '0);
        chk(accept_ok == 1'b1, "R2 plain pkt accept", accept_ok, 1);

        // R3: barrier-bit packet waits for all three uncompleted packets
        send_pkt(0, 1, '0);
        chk(q_state == 2'd1, "R3 enter bbit hold", q_state, 1);
        chk(accept_ok == 1'b0, "R1 no accept in hold", accept_ok, 0);
        complete_one();
        complete_one();
        tick();
        chk(q_state == 2'd1, "R3 still held with one uncompleted", q_state, 1);
        complete_one();
        chk(q_state == 2'd1, "R3 release not before next cycle", q_state, 1);
        tick();
        chk(q_state == 2'd0, "R3 release one cycle after count zero", q_state, 0);

        // R9: unmap with no reads outstanding clears the count
        send_pkt(0, 0, '0);
        send_pkt(0, 1, '0);
        chk(q_state == 2'd1, "R3 bbit hold before unmap", q_state, 1);
        pulse_unmap();
        chk(q_state == 2'd0, "R9 unmap reopens", q_state, 0);
        chk(discard_busy == 1'b0, "R9 no discard", discard_busy, 0);
        send_pkt(0, 1, '0);
        complete_one();
        tick();
        chk(q_state == 2'd0, "R9 count cleared by unmap", q_state, 0);

        // R4/R5: sweep all null patterns, ready steady then toggling
        sweep_mode = 1'b1;
        for (int pass = 0; pass < 2; pass++) begin
            rdy_toggle = (pass == 1);
            for (int m = 0; m < 32; m++) begin
                h = '0;
                for (int s = 0; s < N_DEP; s++)
                    if (m[s]) h[s*HW +: HW] = HW'((s + 1) * 10);
                nreq = 0;
                send_pkt(1, 0, h);
                chk(q_state == 2'd2, "R4 enter barrier hold", q_state, 2);
                wait_open(200, used);
                chk(q_state == 2'd0, "R4 barrier released", q_state, 0);
                chk(nreq == $countones(m), "R5 one request per live handle", nreq, $countones(m));
            end
        end
        rdy_toggle = 1'b0;
        sweep_mode = 1'b0;
        tick();

        // R6: unsatisfied signal forces spaced retries
        sigmem[5] = 8'd0; sigmem[6] = 8'd3;
        nreq = 0; tag0_fires = 0; min_gap = 1000;
        h = '0; h[0 +: HW] = 8'd5; h[HW +: HW] = 8'd6;
        send_pkt(1, 0, h);
        repeat (60) tick();
        chk(q_state == 2'd2, "R4 held while signal nonzero", q_state, 2);
        chk(nreq >= 4, "R6 rounds repeat", nreq, 4);
        chk(min_gap >= int'(retry_dly) + 1, "R6 retry gap", min_gap, int'(retry_dly) + 1);
        sigmem[6] = 8'd0;
        wait_open(100, used);
        chk(q_state == 2'd0, "R4 release after signal cleared", q_state, 0);
        tick();

        // R8: unmap with five reads in flight
        for (int s = 1; s <= 5; s++) sigmem[s] = 8'd7;
        hold = 1'b1;
        nreq = 0;
        h = '0;
        for (int s = 0; s < N_DEP; s++) h[s*HW +: HW] = HW'(s + 1);
        send_pkt(1, 0, h);
        used = 0;
        while (nreq < 5 && used < 50) begin tick(); used++; end
        chk(nreq == 5, "R7 five reads outstanding", nreq, 5);
        chk(discard_busy == 1'b0, "R8 no discard before unmap", discard_busy, 0);
        pulse_unmap();
        chk(discard_busy == 1'b1, "R8 discard raised", discard_busy, 1);
        chk(q_state == 2'd2, "R8 held during drain", q_state, 2);
        chk(accept_ok == 1'b0, "R8 no accept during drain", accept_ok, 0);
        for (int k = 0; k < 4; k++) release_one();
        chk(discard_busy == 1'b1, "R8 discard held until last", discard_busy, 1);
        release_one();
        chk(discard_busy == 1'b0, "R8 discard cleared on last response", discard_busy, 0);
        chk(q_state == 2'd2, "R8 still held on clearing edge", q_state, 2);
        tick();
        chk(q_state == 2'd0, "R8 reopen after drain", q_state, 0);
        chk(nreq == 5, "R8 no request during drain", nreq, 5);
        hold = 1'b0;

        // R7: stray response with nothing outstanding is ignored
        @(negedge clk);
        chk(q_cnt == 0, "R7 bench queue empty", q_cnt, 0);
        sigmem[1] = 8'd0;
        nreq = 0;
        h = '0; h[0 +: HW] = 8'd1;
        send_pkt(1, 0, h);
        wait_open(100, used);
        chk(q_state == 2'd0, "R7 fresh barrier after drain releases", q_state, 0);
        chk(nreq == 1, "R5 single live handle", nreq, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule